// File: doc/BRIEF.md
# Out-of-Order Instruction Issue Queue

This block holds renamed instructions for an out-of-order core until their operands are available, then sends them to execute. Each slot records a thread, a sequence number, up to two physical source tags, an optional destination tag and two kind flags. The flags mark an instruction as non-speculative or as a memory operation. A one-bit-per-register ready table covers the integer and floating-point registers together. Completion broadcasts update both that table and every waiting source operand.

Each cycle the queue offers up to `ISSUE_W` eligible slots. Slot 0 carries the oldest of them, meaning the smallest sequence number, and slot 1 the next oldest. A selected instruction stays resident, marked as issued, until commit or squash releases it. Non-speculative instructions stay parked until a release carrying their exact sequence number arrives. Memory instructions also need an ordering release. Commit frees the older part of one thread, and squash removes the younger part of one thread.

Top module: `iq_issue_queue`

## Requirements
- R1: After reset the queue is empty: `free_cnt_o` equals `DEPTH` (16), no `iss_valid_o` bit is set, no thread is full, and every register counts as ready.
- R2: Among eligible slots, issue slot 0 carries the smallest sequence number and slot 1 the next smallest (16-bit unsigned compare). At most `ISSUE_W` (2) instructions issue per cycle.
- R3: Register tags form one index space: 0..`NUM_INT`-1 (0..95) are integer and the floating-point registers follow at `NUM_INT`..`NUM_INT+NUM_FP`-1 (96..191). A broadcast of one tag never wakes an operand that names a different tag.
- R4: Accepting an instruction with a valid destination clears that register's ready bit. A broadcast of the tag sets it again. A source read at insertion takes its readiness from this table.
- R5: A broadcast in cycle N makes waiting dependents selectable in cycle N+1. An instruction inserted in the same cycle as a matching broadcast records that source as ready.
- R6: An instruction flagged non-speculative is eligible only after a release input has presented its exact sequence number (and its sources are ready). A release with any other number has no effect.
- R7: An instruction flagged as memory is eligible only after a memory-ready input has presented its sequence number, whatever its register readiness.
- R8: An issued instruction keeps its slot (so it is counted as occupied) and is never selected a second time.
- R9: Commit with thread T and number S frees every slot of thread T whose sequence number is less than or equal to S.
- R10: Squash with thread T and number S removes every slot of thread T younger than S in that same cycle, and none of them issues. When squash and commit arrive together, the commit is ignored.
- R11: A thread holding `MAX_PER_THREAD` (8) slots is full: `thread_full_o` is set for it, and `ins_ready_o` is low while `ins_tid_i` names it. `free_cnt_o` reports the number of unoccupied slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert request |
| ins_tid_i | input | 1 | Thread of the inserted instruction |
| ins_seq_i | input | 16 | Sequence number of the inserted instruction |
| ins_src0_vld_i | input | 1 | First source is used |
| ins_src0_i | input | 8 | First source tag |
| ins_src1_vld_i | input | 1 | Second source is used |
| ins_src1_i | input | 8 | Second source tag |
| ins_dst_vld_i | input | 1 | Destination is written |
| ins_dst_i | input | 8 | Destination tag |
| ins_nonspec_i | input | 1 | Instruction waits for non-speculative release |
| ins_mem_i | input | 1 | Instruction waits for memory-ready release |
| ins_ready_o | output | 1 | Insert would be accepted this cycle |
| wake_valid_i | input | 1 | Completion broadcast |
| wake_tag_i | input | 8 | Broadcast destination tag |
| ns_go_valid_i | input | 1 | Non-speculative release |
| ns_go_seq_i | input | 16 | Sequence number released |
| mem_go_valid_i | input | 1 | Memory ordering release |
| mem_go_seq_i | input | 16 | Sequence number released |
| commit_valid_i | input | 1 | Commit request |
| commit_tid_i | input | 1 | Thread to commit |
| commit_seq_i | input | 16 | Youngest sequence number committed |
| squash_valid_i | input | 1 | Squash request |
| squash_tid_i | input | 1 | Thread to squash |
| squash_seq_i | input | 16 | Entries younger than this are removed |
| iss_valid_o | output | 2 | Issue slot valid, slot 0 oldest |
| iss_tid_o | output | 2 | Thread per issue slot |
| iss_seq_o | output | 32 | Sequence number per issue slot |
| iss_dst_o | output | 16 | Destination tag per issue slot |
| free_cnt_o | output | 5 | Unoccupied slots |
| thread_full_o | output | 2 | Per-thread full flag |

## Verification
A stuck or missed ready bit shows up at the issue ports one cycle after the broadcast that should have set it. The dependent either never appears or appears before its producer has broadcast. A slot whose issued mark is lost reappears in the next cycle's issue slots. A slot left occupied, or freed when it should not be, changes `free_cnt_o` on the cycle after the commit or squash. The bench therefore logs every issued sequence number at the ports and checks both the order of the log and the cycle in which each entry shows up.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int SEQ_W = 16;
  localparam int TAG_W = 8;
  localparam int TID_W = 1;

  typedef struct packed {
    logic             vld;
    logic             issued;
    logic [TID_W-1:0] tid;
    logic [SEQ_W-1:0] seq;
    logic [1:0]       src_use;
    logic [1:0]       src_rdy;
    logic [TAG_W-1:0] src0;
    logic [TAG_W-1:0] src1;
    logic [TAG_W-1:0] dst;
    logic             nonspec;
    logic             ns_ok;
    logic             mem;
    logic             mem_ok;
  } iq_entry_t;
endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard #(
  parameter int NUM_INT = 96,
  parameter int NUM_FP  = 96
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    set_vld_i,
  input  logic [iq_pkg::TAG_W-1:0] set_tag_i,
  input  logic                    clr_vld_i,
  input  logic [iq_pkg::TAG_W-1:0] clr_tag_i,
  input  logic [iq_pkg::TAG_W-1:0] rd0_tag_i,
  input  logic [iq_pkg::TAG_W-1:0] rd1_tag_i,
  output logic                    rd0_rdy_o,
  output logic                    rd1_rdy_o
);
  localparam int NREGS = NUM_INT + NUM_FP;

  logic [NREGS-1:0] rdy_q, rdy_d;

  function automatic logic rd(input logic [iq_pkg::TAG_W-1:0] tag,
                              input logic [NREGS-1:0] tbl,
                              input logic sv, input logic [iq_pkg::TAG_W-1:0] st);
    if (int'(tag) >= NREGS) return 1'b1;
    return tbl[tag] | (sv && st == tag);
  endfunction

  assign rd0_rdy_o = rd(rd0_tag_i, rdy_q, set_vld_i, set_tag_i);
  assign rd1_rdy_o = rd(rd1_tag_i, rdy_q, set_vld_i, set_tag_i);

  // a new producer wins over a same-cycle wake of the same tag
  always_comb begin
    rdy_d = rdy_q;
    if (set_vld_i && int'(set_tag_i) < NREGS) rdy_d[set_tag_i] = 1'b1;
    if (clr_vld_i && int'(clr_tag_i) < NREGS) rdy_d[clr_tag_i] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= '1;
    else         rdy_q <= rdy_d;
  end

  p_producer_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_vld_i && int'(clr_tag_i) < NREGS) |=> !rdy_q[$past(clr_tag_i)]);
endmodule

// File: rtl/iq_occupancy.sv
module iq_occupancy #(
  parameter int DEPTH          = 16,
  parameter int NUM_THREADS    = 2,
  parameter int MAX_PER_THREAD = 8,
  localparam int CNT_W         = $clog2(DEPTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DEPTH-1:0]         vld_i,
  input  logic [iq_pkg::TID_W-1:0] tid_i [DEPTH],
  output logic [NUM_THREADS-1:0]   full_o,
  output logic [CNT_W-1:0]         free_o
);
  assign free_o = CNT_W'(DEPTH) - CNT_W'($countones(vld_i));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [CNT_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int i = 0; i < DEPTH; i++)
        if (vld_i[i] && int'(tid_i[i]) == t) cnt = cnt + 1'b1;
    end
    assign full_o[t] = (int'(cnt) >= MAX_PER_THREAD);

    p_thread_cap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(cnt) <= MAX_PER_THREAD);
  end
endmodule

// File: rtl/iq_pick.sv
module iq_pick #(
  parameter int DEPTH   = 16,
  parameter int ISSUE_W = 2,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DEPTH-1:0]         cand_i,
  input  logic [iq_pkg::SEQ_W-1:0] seq_i [DEPTH],
  output logic [ISSUE_W-1:0]       vld_o,
  output logic [IDX_W-1:0]         idx_o [ISSUE_W]
);
  // ISSUE_W chained min-searches, each excluding earlier winners
  always_comb begin
    logic [DEPTH-1:0]         rem;
    logic [iq_pkg::SEQ_W-1:0] best;
    logic                     found;
    rem = cand_i;
    for (int k = 0; k < ISSUE_W; k++) begin
      found    = 1'b0;
      best     = '0;
      idx_o[k] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (rem[i] && (!found || seq_i[i] < best)) begin
          found    = 1'b1;
          best     = seq_i[i];
          idx_o[k] = IDX_W'(i);
        end
      end
      vld_o[k] = found;
      if (found) rem[idx_o[k]] = 1'b0;
    end
  end

  for (genvar k = 1; k < ISSUE_W; k++) begin : g_ord
    p_slot_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o[k] |-> (vld_o[k-1] && seq_i[idx_o[k-1]] < seq_i[idx_o[k]]));
  end
  for (genvar i = 0; i < DEPTH; i++) begin : g_min
    p_oldest_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cand_i[i] |-> (vld_o[0] && seq_i[idx_o[0]] <= seq_i[i]));
  end
endmodule

// File: rtl/iq_issue_queue.sv
module iq_issue_queue
  import iq_pkg::*;
#(
  parameter int DEPTH          = 16,
  parameter int NUM_THREADS    = 2,
  parameter int ISSUE_W        = 2,
  parameter int MAX_PER_THREAD = 8,
  parameter int NUM_INT        = 96,
  parameter int NUM_FP         = 96,
  localparam int IDX_W         = $clog2(DEPTH),
  localparam int CNT_W         = $clog2(DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ins_valid_i,
  input  logic [TID_W-1:0]           ins_tid_i,
  input  logic [SEQ_W-1:0]           ins_seq_i,
  input  logic                       ins_src0_vld_i,
  input  logic [TAG_W-1:0]           ins_src0_i,
  input  logic                       ins_src1_vld_i,
  input  logic [TAG_W-1:0]           ins_src1_i,
  input  logic                       ins_dst_vld_i,
  input  logic [TAG_W-1:0]           ins_dst_i,
  input  logic                       ins_nonspec_i,
  input  logic                       ins_mem_i,
  output logic                       ins_ready_o,
  input  logic                       wake_valid_i,
  input  logic [TAG_W-1:0]           wake_tag_i,
  input  logic                       ns_go_valid_i,
  input  logic [SEQ_W-1:0]           ns_go_seq_i,
  input  logic                       mem_go_valid_i,
  input  logic [SEQ_W-1:0]           mem_go_seq_i,
  input  logic                       commit_valid_i,
  input  logic [TID_W-1:0]           commit_tid_i,
  input  logic [SEQ_W-1:0]           commit_seq_i,
  input  logic                       squash_valid_i,
  input  logic [TID_W-1:0]           squash_tid_i,
  input  logic [SEQ_W-1:0]           squash_seq_i,
  output logic [ISSUE_W-1:0]         iss_valid_o,
  output logic [ISSUE_W*TID_W-1:0]   iss_tid_o,
  output logic [ISSUE_W*SEQ_W-1:0]   iss_seq_o,
  output logic [ISSUE_W*TAG_W-1:0]   iss_dst_o,
  output logic [CNT_W-1:0]           free_cnt_o,
  output logic [NUM_THREADS-1:0]     thread_full_o
);
  iq_entry_t        q [DEPTH];
  logic [DEPTH-1:0] vld_v, elig_v, picked_v;
  logic [TID_W-1:0] tid_a [DEPTH];
  logic [SEQ_W-1:0] seq_a [DEPTH];
  logic [ISSUE_W-1:0] pick_vld;
  logic [IDX_W-1:0]   pick_idx [ISSUE_W];
  logic [IDX_W-1:0]   alloc_idx;
  logic               ins_fire, ins_kill, src0_rdy, src1_rdy;
  iq_entry_t          new_e;

  // ---------------- insertion ----------------
  assign ins_ready_o = (free_cnt_o != '0) && !thread_full_o[ins_tid_i];
  assign ins_fire    = ins_valid_i && ins_ready_o;
  assign ins_kill    = squash_valid_i && ins_tid_i == squash_tid_i && ins_seq_i > squash_seq_i;

  always_comb begin
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_v[i]) alloc_idx = IDX_W'(i);
  end

  iq_scoreboard #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP)) u_sb (
    .clk_i, .rst_ni,
    .set_vld_i (wake_valid_i),
    .set_tag_i (wake_tag_i),
    .clr_vld_i (ins_fire && ins_dst_vld_i && !ins_kill),
    .clr_tag_i (ins_dst_i),
    .rd0_tag_i (ins_src0_i),
    .rd1_tag_i (ins_src1_i),
    .rd0_rdy_o (src0_rdy),
    .rd1_rdy_o (src1_rdy)
  );

  always_comb begin
    new_e         = '0;
    new_e.vld     = !ins_kill;
    new_e.tid     = ins_tid_i;
    new_e.seq     = ins_seq_i;
    new_e.src_use = {ins_src1_vld_i, ins_src0_vld_i};
    new_e.src_rdy = {src1_rdy, src0_rdy};
    new_e.src0    = ins_src0_i;
    new_e.src1    = ins_src1_i;
    new_e.dst     = ins_dst_i;
    new_e.nonspec = ins_nonspec_i;
    new_e.mem     = ins_mem_i;
  end

  // ---------------- per-entry state ----------------
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic wk0, wk1, kill_sq, kill_cm, ns_hit, mem_hit;
    always_comb begin
      wk0     = wake_valid_i && q[i].src0 == wake_tag_i;
      wk1     = wake_valid_i && q[i].src1 == wake_tag_i;
      kill_sq = squash_valid_i && q[i].vld && q[i].tid == squash_tid_i && q[i].seq > squash_seq_i;
      kill_cm = commit_valid_i && !squash_valid_i && q[i].vld && q[i].tid == commit_tid_i
                && q[i].seq <= commit_seq_i;
      ns_hit  = ns_go_valid_i && q[i].nonspec && q[i].seq == ns_go_seq_i;
      mem_hit = mem_go_valid_i && q[i].mem && q[i].seq == mem_go_seq_i;
    end
    assign vld_v[i]  = q[i].vld;
    assign tid_a[i]  = q[i].tid;
    assign seq_a[i]  = q[i].seq;
    assign elig_v[i] = q[i].vld && !q[i].issued && !kill_sq
                       && (&(q[i].src_rdy | ~q[i].src_use))
                       && (!q[i].nonspec || q[i].ns_ok)
                       && (!q[i].mem || q[i].mem_ok);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q[i] <= '0;
      end else if (ins_fire && alloc_idx == IDX_W'(i)) begin
        q[i] <= new_e;
      end else if (kill_sq || kill_cm) begin
        q[i].vld <= 1'b0;
      end else if (q[i].vld) begin
        q[i].src_rdy <= q[i].src_rdy | {wk1, wk0};
        q[i].ns_ok   <= q[i].ns_ok | ns_hit;
        q[i].mem_ok  <= q[i].mem_ok | mem_hit;
        q[i].issued  <= q[i].issued | picked_v[i];
      end
    end
  end

  // ---------------- selection ----------------
  iq_pick #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_pick (
    .clk_i, .rst_ni,
    .cand_i (elig_v),
    .seq_i  (seq_a),
    .vld_o  (pick_vld),
    .idx_o  (pick_idx)
  );

  always_comb begin
    picked_v = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      if (pick_vld[k]) picked_v[pick_idx[k]] = 1'b1;
      iss_valid_o[k]                = pick_vld[k];
      iss_tid_o[k*TID_W +: TID_W]   = q[pick_idx[k]].tid;
      iss_seq_o[k*SEQ_W +: SEQ_W]   = q[pick_idx[k]].seq;
      iss_dst_o[k*TAG_W +: TAG_W]   = q[pick_idx[k]].dst;
    end
  end

  iq_occupancy #(.DEPTH(DEPTH), .NUM_THREADS(NUM_THREADS), .MAX_PER_THREAD(MAX_PER_THREAD)) u_occ (
    .clk_i, .rst_ni,
    .vld_i  (vld_v),
    .tid_i  (tid_a),
    .full_o (thread_full_o),
    .free_o (free_cnt_o)
  );

  // ---------------- checks ----------------
  for (genvar k = 0; k < ISSUE_W; k++) begin : g_chk
    p_squash_masks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (squash_valid_i && iss_valid_o[k]) |->
        !(iss_tid_o[k*TID_W +: TID_W] == squash_tid_i && iss_seq_o[k*SEQ_W +: SEQ_W] > squash_seq_i));
    p_no_reissue_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_valid_o[0] |=> !(iss_valid_o[k]
        && iss_seq_o[k*SEQ_W +: SEQ_W] == $past(iss_seq_o[SEQ_W-1:0])
        && iss_tid_o[k*TID_W +: TID_W] == $past(iss_tid_o[TID_W-1:0])));
  end
  p_refuse_when_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_cnt_o == '0) |-> !ins_ready_o);
endmodule

// File: tb/iq_issue_queue_test.sv
`timescale 1ns/1ps
module iq_issue_queue_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        ins_valid, ins_tid, s0v, s1v, dv, ns, mem;
  logic [15:0] ins_seq;
  logic [7:0]  s0, s1, dst;
  logic        ins_ready;
  logic        wake_v;  logic [7:0]  wake_tag;
  logic        nsg_v;   logic [15:0] nsg_seq;
  logic        memg_v;  logic [15:0] memg_seq;
  logic        cm_v, cm_tid; logic [15:0] cm_seq;
  logic        sq_v, sq_tid; logic [15:0] sq_seq;
  logic [1:0]  iss_valid, iss_tid;
  logic [31:0] iss_seq;
  logic [15:0] iss_dst;
  logic [4:0]  free_cnt;
  logic [1:0]  thr_full;

  iq_issue_queue uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_valid), .ins_tid_i(ins_tid), .ins_seq_i(ins_seq),
    .ins_src0_vld_i(s0v), .ins_src0_i(s0), .ins_src1_vld_i(s1v), .ins_src1_i(s1),
    .ins_dst_vld_i(dv), .ins_dst_i(dst), .ins_nonspec_i(ns), .ins_mem_i(mem),
    .ins_ready_o(ins_ready),
    .wake_valid_i(wake_v), .wake_tag_i(wake_tag),
    .ns_go_valid_i(nsg_v), .ns_go_seq_i(nsg_seq),
    .mem_go_valid_i(memg_v), .mem_go_seq_i(memg_seq),
    .commit_valid_i(cm_v), .commit_tid_i(cm_tid), .commit_seq_i(cm_seq),
    .squash_valid_i(sq_v), .squash_tid_i(sq_tid), .squash_seq_i(sq_seq),
    .iss_valid_o(iss_valid), .iss_tid_o(iss_tid), .iss_seq_o(iss_seq), .iss_dst_o(iss_dst),
    .free_cnt_o(free_cnt), .thread_full_o(thr_full)
  );

  // stimulus and expected issue order
  localparam int NV = 6;
  localparam int vec_seq [NV] = '{5, 3, 9, 1, 7, 4};
  localparam int vec_exp [NV] = '{1, 3, 4, 5, 7, 9};

  int nchk = 0, nfail = 0;
  int log_seq [256];
  int nlog = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 2; k++)
        if (iss_valid[k] && nlog < 256) begin
          log_seq[nlog] = int'(iss_seq[k*16 +: 16]);
          nlog++;
        end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_in();
    ins_valid = 0; ins_tid = 0; ins_seq = 0; s0v = 0; s0 = 0; s1v = 0; s1 = 0;
    dv = 0; dst = 0; ns = 0; mem = 0; wake_v = 0; wake_tag = 0;
    nsg_v = 0; nsg_seq = 0; memg_v = 0; memg_seq = 0;
    cm_v = 0; cm_tid = 0; cm_seq = 0; sq_v = 0; sq_tid = 0; sq_seq = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    clr_in();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic ins(input bit tid, input int seq, input bit u0, input int t0,
                     input bit du, input int d, input bit nsf, input bit mf);
    ins_valid = 1; ins_tid = tid; ins_seq = 16'(seq); s0v = u0; s0 = 8'(t0);
    dv = du; dst = 8'(d); ns = nsf; mem = mf;
  endtask

  int base, occ;

  initial begin
    clr_in();
    #10; rst_n = 1; #1;
    // R1 reset state
    chk("R1 free", int'(free_cnt), 16);
    chk("R1 issue", int'(iss_valid), 0);
    chk("R1 ready", int'(ins_ready), 1);
    chk("R1 full", int'(thr_full), 0);
    @(posedge clk); #1;

    // R4/R2: producer of tag 10 then consumers waiting on it
    ins(0, 50, 0, 0, 1, 10, 0, 0); step();
    for (int v = 0; v < NV; v++) begin
      ins(0, vec_seq[v], 1, 10, 0, 0, 0, 0); step();
    end
    idle(2);
    chk("R4 only producer issued", nlog, 1);
    chk("R4 producer seq", log_seq[0], 50);
    wake_v = 1; wake_tag = 10; step();
    chk("R5 no issue in wake cycle", nlog, 1);
    step();
    chk("R5 dependents next cycle", nlog, 3);
    idle(2);
    for (int v = 0; v < NV; v++) chk("R2 oldest-first order", log_seq[1 + v], vec_exp[v]);
    // R4 register now ready: new consumer issues at once
    ins(0, 60, 1, 10, 0, 0, 0, 0); step(); step();
    chk("R4 set bit seen at insert", log_seq[nlog - 1], 60);
    chk("R8 issued stay allocated", int'(free_cnt), 8);
    chk("R11 thread0 full", int'(thr_full[0]), 1);
    ins_tid = 0; #1; chk("R11 refuse tid0", int'(ins_ready), 0);
    ins_tid = 1; #1; chk("R11 accept tid1", int'(ins_ready), 1);
    clr_in();
    cm_v = 1; cm_tid = 0; cm_seq = 5; step();
    chk("R9 partial commit", int'(free_cnt), 12);
    cm_v = 1; cm_tid = 0; cm_seq = 100; step();
    chk("R9 full commit", int'(free_cnt), 16);

    // R5 same-cycle insert and wake
    ins(0, 200, 0, 0, 1, 20, 0, 0); step();
    base = nlog;
    ins(0, 201, 1, 20, 0, 0, 0, 0); wake_v = 1; wake_tag = 20; step();
    step();
    chk("R5 captured same-cycle wake", nlog, base + 2);
    chk("R5 consumer issued", log_seq[nlog - 1], 201);

    // R3 float vs integer tags
    ins(0, 300, 0, 0, 1, 150, 0, 0); step();
    ins(0, 301, 0, 0, 1, 54, 0, 0); step();
    ins(0, 302, 1, 150, 0, 0, 0, 0); step();
    ins(0, 303, 1, 54, 0, 0, 0, 0); step();
    idle(1);
    base = nlog;
    wake_v = 1; wake_tag = 150; step(); step();
    chk("R3 float wake count", nlog, base + 1);
    chk("R3 float consumer", log_seq[nlog - 1], 302);
    wake_v = 1; wake_tag = 54; step(); step();
    chk("R3 int consumer", log_seq[nlog - 1], 303);

    // R6 non-speculative
    ins(0, 400, 0, 0, 0, 0, 1, 0); step();
    idle(2);
    base = nlog;
    nsg_v = 1; nsg_seq = 401; step(); step();
    chk("R6 wrong seq ignored", nlog, base);
    nsg_v = 1; nsg_seq = 400; step();
    chk("R6 not in release cycle", nlog, base);
    step();
    chk("R6 released", log_seq[nlog - 1], 400);

    // R7 memory ordering
    ins(0, 500, 0, 0, 0, 0, 0, 1); step();
    idle(2);
    chk("R7 held", log_seq[nlog - 1], 400);
    memg_v = 1; memg_seq = 500; step(); step();
    chk("R7 released", log_seq[nlog - 1], 500);
    idle(3);
    occ = 0;
    for (int i = 0; i < nlog; i++) if (log_seq[i] == 500) occ++;
    chk("R8 issued once", occ, 1);
    cm_v = 1; cm_tid = 0; cm_seq = 1000; step();
    chk("R9 drain", int'(free_cnt), 16);

    // R10 squash on thread 1
    ins(1, 599, 0, 0, 1, 30, 0, 0); step();
    for (int s = 600; s < 604; s++) begin ins(1, s, 1, 30, 0, 0, 0, 0); step(); end
    idle(1);
    base = nlog;
    wake_v = 1; wake_tag = 30; step();
    sq_v = 1; sq_tid = 1; sq_seq = 600; step();
    idle(2);
    chk("R10 only older issued", nlog, base + 1);
    chk("R10 survivor", log_seq[nlog - 1], 600);
    chk("R10 freed younger", int'(free_cnt), 14);
    sq_v = 1; sq_tid = 1; sq_seq = 5000; cm_v = 1; cm_tid = 1; cm_seq = 1000; step();
    chk("R10 squash beats commit", int'(free_cnt), 14);
    cm_v = 1; cm_tid = 1; cm_seq = 1000; step();
    chk("R9 thread1 commit", int'(free_cnt), 16);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule